// File: doc/BRIEF.md
# I2C Hung-Bus Recovery Sequencer

This block sits beside an I2C controller and watches the two open-drain lines for a device that keeps one of them low. Both lines pass through two-flop synchronisers, and each line has its own timeout counter. A line is declared hung once its synchronised level has stayed low for a programmed number of system clocks. Any high sample in that interval restarts the count.

If the clock line is the one held low, the block does not try to clear it. It raises a clock-blocked status and an interrupt, and it leaves both lines released. If the data line is held low, the block drives a burst of clock pulses, up to nine of them, with programmable low and high widths. It checks the data line near the end of each high phase. As soon as the data line reads high, it stops pulsing and issues a START, then a STOP, so that every slave is back in step and the bus is idle. It then reports success. If the data line is still low after the ninth pulse, it reports failure and does not issue a START. Software can also start the sequence directly.

Both line outputs are release enables: a 1 lets the line float high and a 0 pulls it low. The board combines them with the other devices as a wired-AND.

Top module: `i2c_hang_recover`

## Requirements
- R1: Both bus inputs pass through two synchronising flops. A line level applied before clock edge n is first used in a decision at edge n+2. After reset, `scl_rel` and `sda_rel` are 1, and `busy`, `done`, `fail`, `scl_err` and `irq` are 0.
- R2: While the block is idle, the sequence starts when synchronised SDA has been low for `cfg_timeout` consecutive cycles with SCL high. With SDA low from before edge 0, `busy` is 0 after edge `cfg_timeout` and 1 after edge `cfg_timeout`+1. A single high sample restarts the count, so low runs shorter than the limit never start a sequence.
- R3: When synchronised SCL has been low for `cfg_timeout` consecutive idle cycles, the block sets `scl_err` and pulses `irq`, with the same edge timing as R2. It never pulls either line low for this condition, and `busy` stays 0.
- R4: While pulsing, every forced SCL low phase lasts `cfg_low` cycles and every high phase lasts `cfg_high` cycles. `sda_rel` stays 1 throughout the pulsing.
- R5: SDA is sampled in the last cycle of each high phase. Pulsing stops after the first pulse in which SDA reads high. If a slave releases SDA at the falling SCL edge of pulse k, exactly k pulses are driven.
- R6: At most 9 pulses are driven. If SDA is still low after the 9th, `fail` is set and `irq` pulses. No START or STOP is issued, and `done` stays 0.
- R7: After SDA is seen high, SDA falls while SCL is high (START) and then rises while SCL is high (STOP). Each phase lasts `cfg_high` cycles. After that, `done` is set and `irq` pulses.
- R8: A one-cycle `start_req` while idle begins the sequence. If SDA is already high, no pulses are driven and only START then STOP follow. If synchronised SCL is low, `scl_err` and `irq` follow one edge later instead, with no drive.
- R9: `irq` lasts one cycle and coincides with exactly one of `done`, `fail` and `scl_err` being set, and with `busy` being 0. These status bits hold until the next sequence starts, and that start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the clock line |
| sda_i | input | 1 | Sensed level of the data line |
| scl_rel | output | 1 | Clock line release; 0 pulls the line low |
| sda_rel | output | 1 | Data line release; 0 pulls the line low |
| start_req | input | 1 | Software request to run the sequence |
| cfg_timeout | input | TMO_W | Consecutive low cycles that mark a line as hung |
| cfg_low | input | HALF_W | Length of each forced SCL low phase, in cycles |
| cfg_high | input | HALF_W | Length of each high, START and STOP phase, in cycles |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence freed the bus |
| fail | output | 1 | Last sequence gave up after the maximum number of pulses |
| scl_err | output | 1 | Clock line found held low |
| irq | output | 1 | One-cycle pulse when a sequence or clock-blocked report ends |

## Verification
The assertions assume that `cfg_low` plus `cfg_high` is at least three cycles. At that length, a release that comes back through the synchronisers still reaches the sample point. They also assume that the configuration does not change while `busy` is high. The stimulus keeps every phase at two cycles or more with a sum of at least five. It changes configuration only between sequences. The bench's slave model lets SDA go on a falling SCL edge, as a real out-of-step slave would. The bench counts pulses, low cycles, START and STOP events on the resolved wired-AND lines, and never through internal signals.

// File: rtl/i2c_hang_pkg.sv
package i2c_hang_pkg;

  localparam int unsigned MAX_PULSES = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_LOW,
    ST_HIGH,
    ST_START,
    ST_STOP
  } seq_state_t;

  // Phase ends in the cycle whose elapsed count reaches len-1 (len 0 acts as 1).
  function automatic logic half_done(input logic [31:0] elapsed, input logic [31:0] len);
    return (elapsed + 32'd1 >= len);
  endfunction

  // Timeout fires in the cycle the low run reaches limit cycles (limit 0 acts as 1).
  function automatic logic tmo_fire(input logic [31:0] run, input logic [31:0] limit);
    return (limit == 32'd0) ? (run == 32'd0) : (run + 32'd1 == limit);
  endfunction

  // True when the pulse now finishing is the last allowed.
  function automatic logic last_pulse(input logic [31:0] pulses_so_far, input logic [31:0] cap);
    return (pulses_so_far + 32'd1 >= cap);
  endfunction

endpackage

// File: rtl/hang_sync.sv
module hang_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] synced
);

  genvar g;
  for (g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/hang_timeout.sv
module hang_timeout import i2c_hang_pkg::*; #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             line,
  input  logic [TMO_W-1:0] limit,
  output logic             fire
);

  logic [TMO_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= '0;
    else if (!enable || line)  run_q <= '0;
    else if (run_q != '1)      run_q <= run_q + 1'b1;
  end

  assign fire = enable && !line && tmo_fire(32'(run_q), 32'(limit));

  // R2: a high sample restarts the low run
  assert_reload_on_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line |=> (run_q == '0));

  // R2: one detection per continuous low run
  assert_single_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

endmodule

// File: rtl/hang_seq.sv
module hang_seq import i2c_hang_pkg::*; #(
  parameter int unsigned HALF_W    = 8,
  parameter int unsigned PULSE_MAX = MAX_PULSES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              tmo_scl,
  input  logic              tmo_sda,
  input  logic              start_req,
  input  logic [HALF_W-1:0] cfg_low,
  input  logic [HALF_W-1:0] cfg_high,
  output logic              watch_en,
  output logic              scl_rel,
  output logic              sda_rel,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              scl_err,
  output logic              irq
);

  localparam int unsigned PCW = $clog2(PULSE_MAX + 1);

  seq_state_t        state_q, state_d;
  logic [HALF_W-1:0] phase_q;
  logic [HALF_W-1:0] cur_len;
  logic [PCW-1:0]    pulses_q;
  logic              done_q, fail_q, err_q, irq_q;
  logic              scl_rel_q, sda_rel_q;

  // named events, visible to the assertions
  logic phase_end, ev_scl_block, ev_launch, ev_sample, ev_sda_free, ev_give_up, ev_finish;

  always_comb cur_len = (state_q == ST_LOW) ? cfg_low : cfg_high;

  assign phase_end    = half_done(32'(phase_q), 32'(cur_len));
  assign ev_scl_block = (state_q == ST_IDLE) && (tmo_scl || (start_req && !scl_s));
  assign ev_launch    = (state_q == ST_IDLE) && !ev_scl_block && ((tmo_sda && scl_s) || start_req);
  assign ev_sample    = (state_q == ST_HIGH) && phase_end;
  assign ev_sda_free  = ev_sample && sda_s;
  assign ev_give_up   = ev_sample && !sda_s && last_pulse(32'(pulses_q), PULSE_MAX);
  assign ev_finish    = (state_q == ST_STOP) && phase_end;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (ev_launch) state_d = ST_CHECK;
      ST_CHECK: state_d = sda_s ? ST_START : ST_LOW;
      ST_LOW:   if (phase_end) state_d = ST_HIGH;
      ST_HIGH: begin
        if (ev_sda_free)     state_d = ST_START;
        else if (ev_give_up) state_d = ST_IDLE;
        else if (ev_sample)  state_d = ST_LOW;
      end
      ST_START: if (phase_end) state_d = ST_STOP;
      ST_STOP:  if (phase_end) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= '0;
      pulses_q  <= '0;
      scl_rel_q <= 1'b1;
      sda_rel_q <= 1'b1;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
      err_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q || state_q == ST_IDLE) phase_q <= '0;
      else                                          phase_q <= phase_q + 1'b1;

      if (ev_launch)      pulses_q <= '0;
      else if (ev_sample) pulses_q <= pulses_q + 1'b1;

      scl_rel_q <= (state_d != ST_LOW);
      sda_rel_q <= (state_d != ST_START);
      irq_q     <= ev_scl_block || ev_give_up || ev_finish;

      if (ev_launch) begin
        done_q <= 1'b0;
        fail_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (ev_scl_block) begin
        err_q  <= 1'b1;
        done_q <= 1'b0;
        fail_q <= 1'b0;
      end
      if (ev_give_up) fail_q <= 1'b1;
      if (ev_finish)  done_q <= 1'b1;
    end
  end

  assign watch_en = (state_q == ST_IDLE);
  assign busy     = (state_q != ST_IDLE);
  assign scl_rel  = scl_rel_q;
  assign sda_rel  = sda_rel_q;
  assign done     = done_q;
  assign fail     = fail_q;
  assign scl_err  = err_q;
  assign irq      = irq_q;

  // R6: pulse count never passes the cap
  assert_pulse_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pulses_q) <= PULSE_MAX);

  // R4: data line left alone while clocking
  assert_sda_free_pulsing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOW || state_q == ST_HIGH) |-> sda_rel);

  // R7: SDA is only pulled down while SCL is released (START shape)
  assert_start_under_high_scl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_rel) |-> scl_rel);

  // R3: no drive at all while idle
  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (scl_rel && sda_rel));

  // R9: interrupt marks exactly one outcome, with the sequence finished
  assert_irq_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($onehot({done_q, fail_q, err_q}) && !busy));

endmodule

// File: rtl/i2c_hang_recover.sv
module i2c_hang_recover import i2c_hang_pkg::*; #(
  parameter int unsigned TMO_W       = 16,
  parameter int unsigned HALF_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_rel,
  output logic              sda_rel,
  input  logic              start_req,
  input  logic [TMO_W-1:0]  cfg_timeout,
  input  logic [HALF_W-1:0] cfg_low,
  input  logic [HALF_W-1:0] cfg_high,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              scl_err,
  output logic              irq
);

  localparam int unsigned LINES = 2;   // index 0: clock line, 1: data line

  logic [LINES-1:0] raw_lines, sync_lines, tmo_fire_v;
  logic             watch_en;

  assign raw_lines = {sda_i, scl_i};

  hang_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (raw_lines),
    .synced (sync_lines)
  );

  genvar g;
  for (g = 0; g < LINES; g++) begin : g_tmo
    hang_timeout #(.TMO_W(TMO_W)) u_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (watch_en),
      .line   (sync_lines[g]),
      .limit  (cfg_timeout),
      .fire   (tmo_fire_v[g])
    );
  end

  hang_seq #(.HALF_W(HALF_W), .PULSE_MAX(MAX_PULSES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (sync_lines[0]),
    .sda_s     (sync_lines[1]),
    .tmo_scl   (tmo_fire_v[0]),
    .tmo_sda   (tmo_fire_v[1]),
    .start_req (start_req),
    .cfg_low   (cfg_low),
    .cfg_high  (cfg_high),
    .watch_en  (watch_en),
    .scl_rel   (scl_rel),
    .sda_rel   (sda_rel),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .scl_err   (scl_err),
    .irq       (irq)
  );

  // R6: an outcome is either success or give-up, never both
  assert_done_fail_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

endmodule

// File: tb/i2c_hang_recover_bench.sv
module i2c_hang_recover_bench;
  localparam int TW = 16;
  localparam int HW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic ext_scl = 1'b1, ext_sda = 1'b1;
  logic start_req = 1'b0;
  logic [TW-1:0] cfg_timeout = 16'd6;
  logic [HW-1:0] cfg_low = 8'd3, cfg_high = 8'd3;
  logic scl_rel, sda_rel, busy, done, fail, scl_err, irq;
  logic scl_line, sda_line, slave_hold;

  // slave model: holds SDA until it has seen slave_k falling SCL edges
  logic slave_on = 1'b0;
  int   slave_base = 0, slave_k = 0;

  // monitors (only ever incremented here)
  int falls = 0, starts = 0, stops = 0, lowcyc = 0, busy_cyc = 0, drive_cyc = 0, cyc = 0;
  int b_falls, b_starts, b_stops, b_low, b_busy, b_drive;
  int tests = 0, failed = 0;

  assign slave_hold = slave_on && ((falls - slave_base) < slave_k);
  assign scl_line   = scl_rel & ext_scl;
  assign sda_line   = sda_rel & ext_sda & ~slave_hold;

  i2c_hang_recover u_i2c_hang_recover (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_rel(scl_rel), .sda_rel(sda_rel), .start_req(start_req),
    .cfg_timeout(cfg_timeout), .cfg_low(cfg_low), .cfg_high(cfg_high),
    .busy(busy), .done(done), .fail(fail), .scl_err(scl_err), .irq(irq)
  );

  always @(negedge scl_line) falls++;
  always @(negedge sda_line) if (scl_line === 1'b1) starts++;
  always @(posedge sda_line) if (scl_line === 1'b1) stops++;
  always @(negedge clk) begin
    if (scl_line === 1'b0) lowcyc++;
    if (busy === 1'b1) busy_cyc++;
    if (scl_rel === 1'b0 || sda_rel === 1'b0) drive_cyc++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, failed + 1);
      $finish;
    end
  end

  typedef struct packed {
    logic       sw;
    logic [7:0] k;
    logic [7:0] lo;
    logic [7:0] hi;
    logic [7:0] exp_p;
    logic       exp_fail;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 8'd1,  8'd3, 8'd3, 8'd1, 1'b0},
    '{1'b0, 8'd3,  8'd4, 8'd2, 8'd3, 1'b0},
    '{1'b1, 8'd5,  8'd2, 8'd5, 8'd5, 1'b0},
    '{1'b0, 8'd9,  8'd3, 8'd3, 8'd9, 1'b0},
    '{1'b0, 8'd10, 8'd2, 8'd3, 8'd9, 1'b1},
    '{1'b1, 8'd0,  8'd2, 8'd4, 8'd0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic mark();
    b_falls = falls; b_starts = starts; b_stops = stops;
    b_low = lowcyc; b_busy = busy_cyc; b_drive = drive_cyc;
  endtask

  task automatic wait_irq(output bit got);
    got = 1'b0;
    for (int i = 0; i < 4000 && !got; i++) begin
      if (irq === 1'b1) got = 1'b1;
      else tick(1);
    end
  endtask

  task automatic hold_slave(input int k);
    slave_base = falls;
    slave_k = k;
    slave_on = 1'b1;
  endtask

  initial begin
    bit got;
    tick(3);
    // R1: reset state
    chk("R1 scl_rel at reset", int'(scl_rel), 1);
    chk("R1 sda_rel at reset", int'(sda_rel), 1);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 status at reset", int'({done, fail, scl_err, irq}), 0);
    rst_n = 1'b1;
    tick(4);

    // R3 / R1: clock line held low, exact detection edge, no drive
    cfg_timeout = 16'd5;
    mark();
    ext_scl = 1'b0;
    tick(6);
    chk("R3 irq before timeout", int'(irq), 0);
    tick(1);
    chk("R1 R3 irq at timeout edge", int'(irq), 1);
    chk("R3 scl_err set", int'(scl_err), 1);
    chk("R3 done clear", int'(done), 0);
    tick(1);
    chk("R9 irq single cycle", int'(irq), 0);
    tick(20);
    chk("R3 no drive while scl hung", drive_cyc - b_drive, 0);
    chk("R3 never busy", busy_cyc - b_busy, 0);
    ext_scl = 1'b1;
    tick(3);
    chk("R9 scl_err sticky", int'(scl_err), 1);

    // R8: software start while clock line low
    cfg_timeout = 16'd60;
    mark();
    ext_scl = 1'b0;
    tick(3);
    start_req = 1'b1;
    tick(1);
    start_req = 1'b0;
    chk("R8 irq on blocked start", int'(irq), 1);
    chk("R8 scl_err on blocked start", int'(scl_err), 1);
    chk("R8 no drive on blocked start", drive_cyc - b_drive, 0);
    ext_scl = 1'b1;
    tick(3);

    // R2: data line timeout, exact start edge
    cfg_timeout = 16'd5;
    cfg_low = 8'd3; cfg_high = 8'd3;
    hold_slave(2);
    tick(6);
    chk("R2 busy before timeout", int'(busy), 0);
    tick(1);
    chk("R2 busy at timeout edge", int'(busy), 1);
    chk("R9 status cleared at launch", int'(scl_err), 0);
    wait_irq(got);
    chk("R2 sequence ends", int'(got), 1);
    chk("R7 done after short hang", int'(done), 1);
    slave_on = 1'b0;
    tick(4);

    // R2: short low runs restart the count
    mark();
    ext_sda = 1'b0; tick(4);
    ext_sda = 1'b1; tick(1);
    ext_sda = 1'b0; tick(4);
    ext_sda = 1'b1; tick(10);
    chk("R2 short runs never launch", busy_cyc - b_busy, 0);
    chk("R2 done unchanged", int'(done), 1);

    // vector table
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      cfg_low = v.lo; cfg_high = v.hi; cfg_timeout = 16'd6;
      if (v.k != 0) hold_slave(int'(v.k));
      tick(2);
      mark();
      if (v.sw) begin
        start_req = 1'b1; tick(1); start_req = 1'b0;
      end
      wait_irq(got);
      chk("R9 irq raised", int'(got), 1);
      chk("R5 R6 pulse count", falls - b_falls, int'(v.exp_p));
      chk("R4 low cycles", lowcyc - b_low, int'(v.exp_p) * int'(v.lo));
      chk("R7 START count", starts - b_starts, v.exp_fail ? 0 : 1);
      chk("R7 STOP count", stops - b_stops, v.exp_fail ? 0 : 1);
      chk("R6 fail flag", int'(fail), int'(v.exp_fail));
      chk("R7 done flag", int'(done), v.exp_fail ? 0 : 1);
      chk("R9 busy low at irq", int'(busy), 0);
      if (v.k == 0) chk("R8 idle-bus start gives no pulses", falls - b_falls, 0);
      tick(1);
      chk("R9 irq one cycle", int'(irq), 0);
      chk("R9 outcome sticky", int'({done, fail}), v.exp_fail ? 1 : 2);
      slave_on = 1'b0;
      tick(4);
    end

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule